// File: doc/BRIEF.md
# Serial Converter Output Port with Sleep Control

This block is the device-side digital logic of a 12-bit sampling converter with a serial data output that can be switched off. It stands in for the converter core with a stub input: at the end of each conversion it captures a signed sample from that input, limits it to the converter's code range and holds it for readout. The convert input and the shift-clock input come from an external host. Both are brought into a fast reference clock through two-stage synchronisers, and every time interval is counted in that clock.

A rising edge on the convert line starts a conversion of fixed length and switches the data output off. If convert is still high when the conversion ends, the port goes to sleep and holds the captured code. A falling edge on convert wakes the port. It starts the acquisition timer, turns the output on and presents the most significant result bit at once. Each falling edge of the shift clock then moves the output one bit lower. Once the last bit has gone out, zeros follow for as long as the host keeps clocking. A conversion that starts before acquisition has finished still runs, but it sets a sticky error flag. A 2-bit status output shows the current phase.

Top module: `sdo_port`

## Requirements
- R1: A rising edge on conv_i starts a conversion lasting CONV_CYC reference cycles (default 150, which is 1.5 us at 100 MHz). During the conversion phase_o reads 1 and sdo_oe_o is 0. A further rising edge during a conversion is ignored.
- R2: When a conversion ends with conv_i still high, phase_o reads 2 (sleep) and sdo_oe_o stays 0. The captured code is held during sleep, whatever sample_i does.
- R3: A falling edge on conv_i outside a conversion sets sdo_oe_o to 1 and puts bit 11 of the held code on sdo_o. phase_o reads 3 (shift) while bits remain, and an ACQ_CYC-cycle acquisition timer starts (default 50 cycles, 0.5 us).
- R4: Each falling edge of sck_i while sdo_oe_o is 1 moves sdo_o to the next lower code bit, so the code leaves most significant bit first.
- R5: After bit 0 has been presented, each further falling sck_i edge drives sdo_o to 0, with no limit, and phase_o reads 0 (acquire).
- R6: The captured code is straight binary. A sample_i value (signed) above 4095 gives 4095, a value below 0 gives 0, and any other value passes through unchanged.
- R7: A conversion that starts less than ACQ_CYC cycles after the latest wake or reset sets early_err_o, and the conversion still runs. Only reset clears early_err_o.
- R8: After reset with conv_i low, phase_o is 0, sdo_oe_o is 1, sdo_o is 0 and early_err_o is 0, and the acquisition timer runs from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all timing |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert control from the host, asynchronous |
| sck_i | input | 1 | Shift clock from the host, asynchronous |
| sample_i | input | DATA_W+2 | Signed stub sample in place of the converter core |
| sdo_o | output | 1 | Serial result bit; 0 while the output is off |
| sdo_oe_o | output | 1 | Output driver enable |
| phase_o | output | 2 | Phase: 0 acquire, 1 convert, 2 sleep, 3 shift |
| early_err_o | output | 1 | Sticky flag for a conversion started before acquisition finished |

## Verification
A wrong phase register appears on phase_o and sdo_oe_o within about three reference cycles of the convert edge that should have moved it. A conversion counter that is wrong by even a few cycles shows when the phase is sampled just before and just after the nominal conversion end. Damage to the held code or to the bit counter appears in the first word read after the fault, as a wrong bit, as the bits in the wrong order, or as a nonzero value after bit 0. A faulty acquisition timer shows on early_err_o at the first conversion that starts early, or one that should not have counted as early.

// File: rtl/sdo_port_pkg.sv
package sdo_port_pkg;
   typedef enum logic [1:0] {
      PH_ACQ   = 2'd0,
      PH_CONV  = 2'd1,
      PH_SLEEP = 2'd2,
      PH_SHIFT = 2'd3
   } phase_e;
endpackage

// File: rtl/sdo_sync.sv
module sdo_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial assert (STAGES >= 2);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdo_sequencer.sv
module sdo_sequencer #(
   parameter int unsigned CONV_CYC = 150,
   parameter int unsigned ACQ_CYC  = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_s_i,
   output logic conv_lvl_o,
   output logic busy_o,
   output logic oe_o,
   output logic done_o,
   output logic wake_o,
   output logic early_err_o
);
   localparam int unsigned CW = $clog2(CONV_CYC + 1);
   localparam int unsigned AW = $clog2(ACQ_CYC + 1);

   initial assert (CONV_CYC >= 2);
   initial assert (ACQ_CYC >= 1);

   logic          conv_d, busy_q, oe_q, acq_ok_q, err_q;
   logic [CW-1:0] conv_cnt;
   logic [AW-1:0] acq_cnt;
   logic          rise, fall;

   assign rise   = conv_s_i && !conv_d;
   assign fall   = !conv_s_i && conv_d;
   assign done_o = busy_q && (conv_cnt == '0);
   assign wake_o = (fall && !busy_q) || (done_o && !conv_s_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_d   <= 1'b0;
         busy_q   <= 1'b0;
         conv_cnt <= '0;
         oe_q     <= 1'b1;
         acq_cnt  <= AW'(ACQ_CYC - 1);
         acq_ok_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         conv_d <= conv_s_i;
         if (rise && !busy_q) begin
            busy_q   <= 1'b1;
            conv_cnt <= CW'(CONV_CYC - 1);
            if (!acq_ok_q) err_q <= 1'b1;
         end else if (busy_q) begin
            if (conv_cnt == '0) busy_q <= 1'b0;
            else                conv_cnt <= conv_cnt - 1'b1;
         end
         oe_q <= !conv_s_i && !(busy_q && (conv_cnt != '0));
         if (wake_o) begin
            acq_cnt  <= AW'(ACQ_CYC - 1);
            acq_ok_q <= 1'b0;
         end else if (!acq_ok_q) begin
            if (acq_cnt == '0) acq_ok_q <= 1'b1;
            else               acq_cnt  <= acq_cnt - 1'b1;
         end
      end
   end

   assign conv_lvl_o  = conv_d;
   assign busy_o      = busy_q;
   assign oe_o        = oe_q;
   assign early_err_o = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R7
   AST_OE_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !busy_q) |=> !oe_q); // R1
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
   parameter int unsigned DATA_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W+1:0] sample_i,
   input  logic                     load_i,
   input  logic                     wake_i,
   input  logic                     shift_i,
   output logic                     msb_o,
   output logic [$clog2(DATA_W+1)-1:0] bits_left_o
);
   localparam int unsigned BW = $clog2(DATA_W + 1);
   localparam logic [DATA_W-1:0] FULL = '1;

   initial assert (DATA_W >= 2);

   logic [DATA_W-1:0] code, sreg_q;
   logic [BW-1:0]     left_q;

   always_comb begin
      if (sample_i < 0)                          code = '0;
      else if (sample_i > $signed({2'b00, FULL})) code = FULL;
      else                                       code = sample_i[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         left_q <= '0;
      end else begin
         if (load_i)       sreg_q <= code;
         else if (shift_i) sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
         if (wake_i)                        left_q <= BW'(DATA_W);
         else if (shift_i && left_q != '0)  left_q <= left_q - 1'b1;
      end
   end

   assign msb_o       = sreg_q[DATA_W-1];
   assign bits_left_o = left_q;

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !wake_i && left_q != '0) |=> (left_q == BW'($past(left_q) - 1'b1))); // R4
endmodule

// File: rtl/sdo_port.sv
module sdo_port #(
   parameter int unsigned DATA_W   = 12,
   parameter int unsigned CONV_CYC = 150,
   parameter int unsigned ACQ_CYC  = 50,
   parameter int unsigned SYNC_N   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     conv_i,
   input  logic                     sck_i,
   input  logic signed [DATA_W+1:0] sample_i,
   output logic                     sdo_o,
   output logic                     sdo_oe_o,
   output logic [1:0]               phase_o,
   output logic                     early_err_o
);
   import sdo_port_pkg::*;

   localparam int unsigned BW = $clog2(DATA_W + 1);

   logic          conv_s, sck_s, sck_d, sck_fall;
   logic          conv_lvl, busy, oe, done, wake, msb;
   logic [BW-1:0] bits_left;
   phase_e        ph;

   sdo_sync #(.STAGES(SYNC_N)) conv_sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(conv_i), .q_o(conv_s));
   sdo_sync #(.STAGES(SYNC_N)) sck_sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end
   assign sck_fall = sck_d && !sck_s;

   sdo_sequencer #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) seq_i (
      .clk(clk), .rst_n(rst_n), .conv_s_i(conv_s),
      .conv_lvl_o(conv_lvl), .busy_o(busy), .oe_o(oe),
      .done_o(done), .wake_o(wake), .early_err_o(early_err_o));

   sdo_shifter #(.DATA_W(DATA_W)) shf_i (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
      .load_i(done), .wake_i(wake), .shift_i(sck_fall && oe),
      .msb_o(msb), .bits_left_o(bits_left));

   always_comb begin
      if (busy)                 ph = PH_CONV;
      else if (conv_lvl)        ph = PH_SLEEP;
      else if (bits_left != '0) ph = PH_SHIFT;
      else                      ph = PH_ACQ;
   end

   assign phase_o  = ph;
   assign sdo_oe_o = oe;
   assign sdo_o    = oe && msb;

   AST_HIZ_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_CONV) |-> !sdo_oe_o); // R1
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_SLEEP && $past(phase_o == PH_SLEEP)) |-> ($stable(msb) && !sdo_oe_o)); // R2
   AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && bits_left == '0) |-> !sdo_o); // R5
endmodule

// File: tb/sdo_port_tb_top.sv
module sdo_port_tb_top;
   localparam int CONV = 150;
   localparam int ACQ  = 50;
   localparam int NV   = 7;
   localparam logic signed [13:0] VEC [NV] = '{14'sd0, 14'sd4095, 14'sd1234, 14'sd5000,
                                               -14'sd7, 14'sd2730, 14'sd1};

   logic clk = 1'b0, rst_n = 1'b0, conv = 1'b0, sck = 1'b0;
   logic signed [13:0] sample = '0;
   logic sdo, oe, err;
   logic [1:0] phase;
   int nchk = 0, nbad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sdo_port dut_i (.clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck),
                   .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe),
                   .phase_o(phase), .early_err_o(err));

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_code(input int s);
      if (s < 0) return 0;
      if (s > 4095) return 4095;
      return s;
   endfunction

   task automatic convert(input int s);
      sample = 14'(s);
      conv = 1'b1;
      wait_n(CONV - 5);
      chk("R1 phase in conversion", int'(phase), 1);
      chk("R1 output off in conversion", int'(oe), 0);
      wait_n(10);
      chk("R2 sleep after conversion", int'(phase), 2);
      chk("R2 output off in sleep", int'(oe), 0);
   endtask

   task automatic wake_read(output int word);
      conv = 1'b0;
      wait_n(4);
      chk("R3 output on after wake", int'(oe), 1);
      chk("R3 shift phase after wake", int'(phase), 3);
      word = int'(sdo);
      for (int k = 1; k < 12; k++) begin
         sck = 1'b1; wait_n(3);
         sck = 1'b0; wait_n(4);
         word = (word << 1) | int'(sdo);
      end
      sck = 1'b1; wait_n(3);
      sck = 1'b0; wait_n(4);
      chk("R5 acquire phase after last bit", int'(phase), 0);
      chk("R5 zero after bit 0", int'(sdo), 0);
      for (int k = 0; k < 2; k++) begin
         sck = 1'b1; wait_n(3);
         sck = 1'b0; wait_n(4);
         chk("R5 trailing zero", int'(sdo), 0);
      end
   endtask

   initial begin
      wait_n(100000);
      nchk++; nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      if (!finished) $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      int w;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      chk("R8 reset phase", int'(phase), 0);
      chk("R8 reset output enable", int'(oe), 1);
      chk("R8 reset sdo", int'(sdo), 0);
      chk("R8 reset error flag", int'(err), 0);
      wait_n(ACQ + 10);

      for (int v = 0; v < NV; v++) begin
         convert(int'(VEC[v]));
         wake_read(w);
         chk("R4 R6 serial word", w, exp_code(int'(VEC[v])));
      end
      chk("R7 no error after spaced conversions", int'(err), 0);

      // R2: code held while the stub input changes during sleep
      convert(1500);
      sample = 14'sd3000;
      wait_n(30);
      chk("R2 still asleep", int'(phase), 2);
      wake_read(w);
      chk("R2 held code", w, 1500);

      // R7: early conversion start
      convert(100);
      conv = 1'b0;
      wait_n(10);
      conv = 1'b1;
      wait_n(5);
      chk("R7 error set on early start", int'(err), 1);
      chk("R7 conversion proceeds", int'(phase), 1);
      wait_n(CONV + 10);
      chk("R7 reaches sleep", int'(phase), 2);
      wake_read(w);
      chk("R7 word of early conversion", w, 100);
      convert(200);
      wake_read(w);
      chk("R7 flag sticky", int'(err), 1);

      // R8: reset clears flag; timer runs from reset
      rst_n = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      chk("R8 error cleared by reset", int'(err), 0);
      conv = 1'b1;
      wait_n(5);
      chk("R8 early start after reset", int'(err), 1);
      wait_n(CONV + 10);
      conv = 1'b0;
      wait_n(5);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule